// File: doc/BRIEF.md
# SPI Slave with Select Framing

This block is the receive and transmit end of a byte-wide serial link in which another device supplies the serial clock and an active-low select. It shifts in one byte from MOSI while shifting one byte out on MISO, most significant bit first, and hands each completed received byte to the core as a parallel value with a one-cycle valid pulse. The core offers the next outgoing byte through a parallel input and a load strobe. The block holds that byte until the next byte boundary, so a load during a transfer never disturbs the bits already on the wire.

The serial clock, select and MOSI are brought into the system clock domain through two-flop synchronizers, and all edges are detected there. A static polarity input sets the idle level of the serial clock. A static phase input sets the framing. With phase 0, the falling edge of the select starts each byte, and the first bit appears on MISO before any clock edge. With phase 1, the select may stay low across a burst of bytes, and byte boundaries come from the clock edge count alone. Raising the select at any point turns off the MISO driver and drops any partial byte.

Top module: `spi_select_slave`

## Requirements
- R1: After reset, miso_oe is 0, rx_valid is 0 and rx_data is 0x00.
- R2: Bits arrive on MOSI most significant first. After the eighth sampling edge of a byte, rx_data takes the received byte and rx_valid is 1 for exactly one system clock cycle.
- R3: With cpha=0, MOSI is sampled on the leading clock edge and MISO changes on the trailing edge. Bit 7 of the held transmit byte appears on MISO after the select falls and before the first clock edge.
- R4: With cpha=1, MISO changes on the leading edge and MOSI is sampled on the trailing edge. The first leading edge after a byte boundary puts bit 7 of the held byte on MISO. The select may stay low across several bytes, and every eight edge pairs form one byte.
- R5: With cpol=0 the leading edge is the rising edge. With cpol=1 the clock idles high and the leading edge is the falling edge.
- R6: miso_oe is 1 while the synchronized select is low and 0 within three system clock cycles after the select goes high.
- R7: Serial clock edges that occur while the select is high have no effect: no rx_valid, and the next selected byte is received intact.
- R8: If the select rises before the eighth sampling edge, the partial byte is dropped, no rx_valid is produced, and the next byte starts again from bit 7.
- R9: A byte presented with tx_load during a transfer is sent as the next byte, not the current one. If no new byte is loaded, the previous byte is sent again.
- R10: rx_data keeps its last complete byte until another complete byte arrives, including across an aborted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level (static) |
| cpha | input | 1 | Clock phase select (static) |
| sck | input | 1 | Serial clock from the remote master |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| tx_data | input | 8 | Next byte to transmit |
| tx_load | input | 1 | Strobe capturing tx_data |
| rx_data | output | 8 | Last completely received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |

## Verification
The hardest case to reach from the ports is the byte boundary in a phase 1 burst with the select held low. A transmit byte loaded in the middle of one byte must first appear at the leading edge that begins the next byte, and must then repeat on the byte after that. The bench drives a three-byte burst and strobes a new transmit byte at the fourth bit of the first byte. It collects MISO as a master would and compares each byte against the order the requirements predict. Aborted bytes and clock toggles with the select high are placed just before complete bytes. A stale bit counter therefore shows up as a corrupt received value in the scoreboard.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

  // Serial event flags, one system cycle wide, derived from the synchronized inputs.
  typedef struct packed {
    logic sel;       // select currently asserted (synchronized)
    logic sel_fall;  // select just asserted
    logic lead;      // leading serial clock edge while selected
    logic trail;     // trailing serial clock edge while selected
  } spi_evt_t;

  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned WORD_W_DEF     = 8;

endpackage

// File: rtl/spi_sync_bit.sv
module spi_sync_bit #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_n;
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/spi_edge_detect.sv
module spi_edge_detect
  import spi_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpol,
  input  logic     sck_s,
  input  logic     ss_n_s,
  output spi_evt_t evt
);

  logic sck_d_q;
  logic ss_d_q;
  logic rise;
  logic fall;
  logic sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      ss_d_q  <= 1'b1;
    end else begin
      sck_d_q <= sck_s;
      ss_d_q  <= ss_n_s;
    end
  end

  always_comb begin
    rise         = sck_s & ~sck_d_q;
    fall         = ~sck_s & sck_d_q;
    sel          = ~ss_n_s;
    evt.sel      = sel;
    evt.sel_fall = sel & ss_d_q;
    // Clock edges only count while the select is low.
    evt.lead     = sel & (cpol ? fall : rise);
    evt.trail    = sel & (cpol ? rise : fall);
  end

  AST_LEAD_TRAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.lead && evt.trail)); // R5

  AST_NO_EDGE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_s |-> !(evt.lead || evt.trail)); // R7

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_data,
  output logic [WORD_W-1:0] tx_next
);

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] hold_n;

  always_comb begin
    hold_n = hold_q;
    if (tx_load) begin
      hold_n = tx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_n;
    end
  end

  assign tx_next = hold_q;

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_next == $past(tx_data)); // R9

  AST_HOLD_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_load |=> $stable(tx_next)); // R9

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_sel_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  spi_evt_t          evt,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] tx_next,
  output logic              miso,
  output logic              miso_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q,  cnt_n;
  logic [WORD_W-1:0] rxs_q,  rxs_n;
  logic [WORD_W-1:0] txs_q,  txs_n;
  logic [WORD_W-1:0] rxd_q,  rxd_n;
  logic              vld_q,  vld_n;
  logic              oe_q,   oe_n;
  logic              samp;
  logic              shft;
  logic              frame_load;

  always_comb begin
    // Phase 0: sample on leading, shift on trailing; phase 1: the reverse.
    samp       = cpha ? evt.trail : evt.lead;
    shft       = cpha ? evt.lead  : evt.trail;
    frame_load = evt.sel_fall & ~cpha;

    cnt_n = cnt_q;
    rxs_n = rxs_q;
    txs_n = txs_q;
    rxd_n = rxd_q;
    vld_n = 1'b0;
    oe_n  = evt.sel;

    if (!evt.sel) begin
      cnt_n = '0;
    end else begin
      if (frame_load) begin
        txs_n = tx_next;
      end
      if (samp) begin
        rxs_n = {rxs_q[WORD_W-2:0], mosi_s};
        if (cnt_q == LAST_BIT) begin
          cnt_n = '0;
          rxd_n = {rxs_q[WORD_W-2:0], mosi_s};
          vld_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (shft) begin
        if (cnt_q == '0) begin
          txs_n = tx_next;
        end else begin
          txs_n = {txs_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rxs_q <= '0;
      txs_q <= '0;
      rxd_q <= '0;
      vld_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      rxs_q <= rxs_n;
      txs_q <= txs_n;
      rxd_q <= rxd_n;
      vld_q <= vld_n;
      oe_q  <= oe_n;
    end
  end

  assign miso     = txs_q[WORD_W-1];
  assign miso_oe  = oe_q;
  assign rx_data  = rxd_q;
  assign rx_valid = vld_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2

  AST_VALID_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(samp)); // R2

  AST_DESEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.sel |=> (cnt_q == '0) && !rx_valid); // R8

  AST_RXD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data)); // R10

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !shft && !frame_load |=> $stable(txs_q)); // R3

endmodule

// File: rtl/spi_select_slave.sv
module spi_select_slave
  import spi_sel_pkg::*;
#(
  parameter int unsigned WORD_W     = WORD_W_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic              miso_oe,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_load,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int unsigned N_SYNC = 3; // sck, ss_n, mosi

  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] syn_out;
  spi_evt_t          evt;
  logic [WORD_W-1:0] tx_next;

  assign raw_in = {mosi, ss_n, sck};

  for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
    spi_sync_bit #(
      .STAGES  (SYNC_DEPTH),
      .RST_VAL (gi == 1)
    ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_in[gi]),
      .q_sync  (syn_out[gi])
    );
  end

  spi_edge_detect i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpol   (cpol),
    .sck_s  (syn_out[0]),
    .ss_n_s (syn_out[1]),
    .evt    (evt)
  );

  spi_tx_hold #(.WORD_W(WORD_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_load (tx_load),
    .tx_data (tx_data),
    .tx_next (tx_next)
  );

  spi_shift_engine #(.WORD_W(WORD_W)) i_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpha     (cpha),
    .evt      (evt),
    .mosi_s   (syn_out[2]),
    .tx_next  (tx_next),
    .miso     (miso),
    .miso_oe  (miso_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n && $past(ss_n, 1) && $past(ss_n, 2) && $past(ss_n, 3) |-> !miso_oe); // R6

endmodule

// File: tb/test_spi_select_slave.sv
module test_spi_select_slave;

  localparam int HP = 8; // serial half period in system cycles

  logic       clk;
  logic       rst_n;
  logic       cpol, cpha, sck, mosi, ss_n;
  logic       miso, miso_oe;
  logic [7:0] tx_data;
  logic       tx_load;
  logic [7:0] rx_data;
  logic       rx_valid;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [7:0] exp_q[$];

  spi_select_slave i_spi_select_slave (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sck(sck),
    .mosi(mosi), .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe),
    .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] v);
    tx_data = v;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic sel_low();
    ss_n = 1'b0;
    wait_cyc(HP);
  endtask

  task automatic sel_high();
    wait_cyc(HP);
    ss_n = 1'b1;
    wait_cyc(HP);
  endtask

  // Master side of one byte (or a partial byte when nbits < 8).
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi, input int nbits,
                      input int ld_at, input logic [7:0] ld_val, input string req);
    logic [7:0] mi = '0;
    if (nbits == 8) exp_q.push_back(mo);
    for (int i = 0; i < nbits; i++) begin
      if (i == ld_at) load_tx(ld_val);
      if (!cpha) begin
        mosi = mo[7-i];
        wait_cyc(HP);
        mi[7-i] = miso;
        sck = ~cpol;
        wait_cyc(HP);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mo[7-i];
        wait_cyc(HP);
        mi[7-i] = miso;
        sck = cpol;
        wait_cyc(HP);
      end
      if (i == 0) check(miso_oe === 1'b1, "R6 oe while selected", {7'd0, miso_oe}, 8'h01);
    end
    if (nbits == 8) check(mi === exp_mi, req, mi, exp_mi);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 R8 unexpected rx_valid actual=%02h expected=none", rx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          errors++;
          $display("FAIL R2 rx_data actual=%02h expected=%02h", rx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; sck = 1'b0; mosi = 1'b0; ss_n = 1'b1;
    tx_data = '0; tx_load = 1'b0;
    wait_cyc(5);
    // R1 reset state
    check(miso_oe === 1'b0, "R1 oe", {7'd0, miso_oe}, 8'h00);
    check(rx_valid === 1'b0, "R1 valid", {7'd0, rx_valid}, 8'h00);
    check(rx_data === 8'h00, "R1 data", rx_data, 8'h00);
    rst_n = 1'b1;
    wait_cyc(5);
    check(rx_data === 8'h00, "R1 data after release", rx_data, 8'h00);

    // R3 R5: phase 0, polarity 0
    load_tx(8'hA5);
    sel_low();
    xfer(8'h3C, 8'hA5, 8, -1, 8'h00, "R3 phase0 miso byte");
    sel_high();
    check(miso_oe === 1'b0, "R6 oe off", {7'd0, miso_oe}, 8'h00);
    // R9: no new load, byte repeats; load mid-byte applies next frame
    sel_low();
    xfer(8'hC3, 8'hA5, 8, 3, 8'h96, "R9 repeat and hold");
    sel_high();
    sel_low();
    xfer(8'h81, 8'h96, 8, -1, 8'h00, "R9 loaded byte next frame");
    sel_high();

    // R7: clock while deselected
    for (int k = 0; k < 6; k++) begin
      sck = ~sck; mosi = ~mosi; wait_cyc(HP);
    end
    sck = cpol;
    wait_cyc(HP);
    check(miso_oe === 1'b0, "R7 R6 oe while toggling", {7'd0, miso_oe}, 8'h00);
    check(rx_data === 8'h81, "R7 rx_data untouched", rx_data, 8'h81);
    sel_low();
    xfer(8'h5F, 8'h96, 8, -1, 8'h00, "R7 byte after ignored clocks");
    sel_high();

    // R8 R10: abort after 3 bits
    sel_low();
    xfer(8'hFF, 8'h00, 3, -1, 8'h00, "R8 partial");
    sel_high();
    check(rx_data === 8'h5F, "R10 rx_data kept after abort", rx_data, 8'h5F);
    sel_low();
    xfer(8'h12, 8'h96, 8, -1, 8'h00, "R8 byte after abort");
    sel_high();

    // R5: polarity 1, phase 0
    cpol = 1'b1; sck = 1'b1;
    wait_cyc(HP);
    load_tx(8'hE7);
    sel_low();
    xfer(8'hB4, 8'hE7, 8, -1, 8'h00, "R5 cpol1 phase0");
    sel_high();

    // R4 R9: phase 1 burst, polarity 0, select held low
    cpol = 1'b0; sck = 1'b0; cpha = 1'b1;
    wait_cyc(HP);
    load_tx(8'h3A);
    sel_low();
    xfer(8'h11, 8'h3A, 8, 3, 8'hC5, "R4 burst byte1");
    xfer(8'h22, 8'hC5, 8, -1, 8'h00, "R4 R9 burst byte2");
    xfer(8'h44, 8'hC5, 8, -1, 8'h00, "R4 R9 burst byte3 repeat");
    sel_high();

    // R4 R5: phase 1 polarity 1
    cpol = 1'b1; sck = 1'b1;
    wait_cyc(HP);
    load_tx(8'h69);
    sel_low();
    xfer(8'hD2, 8'h69, 8, -1, 8'h00, "R4 R5 cpol1 phase1");
    // R8 in phase 1: abort mid-byte then a clean byte
    xfer(8'hFF, 8'h00, 5, -1, 8'h00, "R8 partial phase1");
    sel_high();
    sel_low();
    xfer(8'h7E, 8'h69, 8, -1, 8'h00, "R8 phase1 after abort");
    sel_high();

    wait_cyc(20);
    check(exp_q.size() == 0, "R2 all bytes delivered", 8'(exp_q.size()), 8'h00);
    check(rx_data === 8'h7E, "R10 final rx_data", rx_data, 8'h7E);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule